// File: doc/BRIEF.md
# Quad-Output Serial Flash Read Controller

This block is the host side of a fast read from a serial NOR flash in which the returned data comes back on four lines at once. A request carries a 24-bit start address and a byte count. When the request is accepted, the controller pulls chip select low and runs a serial clock derived from the system clock. It sends the 8-bit read command and the address one bit per clock on line 0. It then lets eight idle clocks pass and releases line 0. From that point it collects four bits per clock from the four data lines and packs each pair of nibbles into a byte, which it presents on a valid/ready stream.

The memory advances its address by itself, so one request can read any number of consecutive bytes. If the consumer stops taking bytes, the controller holds the serial clock at its idle level at a byte boundary and keeps chip select low, so no data is lost. A quad-enable status input gates every request. A request that arrives while this input is low is refused with an error pulse and causes no bus activity. A zero-length request completes at once. Between transfers, chip select stays high for at least two serial clock periods.

The line drivers are outside the block. The controller gives line 0 as an output value with an enable, and takes all four lines in as inputs.

Top module: `qspi_quad_reader`

## Requirements
- R1: The first 8 serial clocks after chip select falls carry the command byte 0x6B on `io0_o`, most significant bit first, with one bit captured by the memory on each rising edge of `sclk`.
- R2: Serial clocks 8 to 31 carry the request address on `io0_o`, bit 23 first.
- R3: Eight dummy clocks (32 to 39) follow the address, and data starts at clock 40. Chip select stays low for exactly 40 + 2·N rising edges of `sclk`, where N is the byte count.
- R4: Each byte takes two clocks, high nibble first. In the first clock `io_i[3:0]` supplies bits 7..4 and in the second clock it supplies bits 3..0. Bytes come out on `rd_data` in increasing address order, starting at the request address and wrapping at 24 bits.
- R5: `io0_oe` is high during clocks 0 to 31. It falls with the falling edge that follows clock 31, so it is low before the first falling edge on which the memory drives data. It is never high while chip select is high.
- R6: A request accepted while `quad_en` is 0 gives a one-cycle `err` pulse on the cycle after acceptance. It does not pull chip select low and gives no `done`.
- R7: A request with a byte count of zero gives a one-cycle `done` pulse on the cycle after acceptance, with no chip select or serial clock activity.
- R8: Whenever `cs_n` is high, `sclk` sits at the idle level set by parameter CPOL (0 = idle low, 1 = idle high). Launch happens on the falling edge and capture on the rising edge.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` holds its value. The serial clock pauses at its idle level with `cs_n` low, and every byte is delivered once.
- R10: Between the end of one transfer and the start of the next, `cs_n` stays high for at least 2·CLK_DIV system clock cycles.
- R11: `done` pulses once per read, after the last byte has been taken and with `cs_n` high. `req_ready` is low from acceptance until that point.
- R12: After reset, `cs_n` is 1, `sclk` is at the idle level, `io0_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 24 | Start address of the read |
| req_len | input | LEN_W | Number of bytes to read |
| quad_en | input | 1 | Memory status shows four-line output enabled |
| sclk | output | 1 | Serial clock to the memory |
| cs_n | output | 1 | Chip select, active low |
| io0_o | output | 1 | Value driven on data line 0 |
| io0_oe | output | 1 | Drive enable for data line 0 |
| io_i | input | 4 | Data lines 3..0 as seen at the pads |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle pulse at the end of a read |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
If the clock-index counter or the header shifter goes wrong, the memory model receives a wrong command or address. This shows at chip select release in the same transfer, and the bytes returned come from the wrong place. If the nibble phase is off by one clock, the very first byte of the transfer is wrong: its nibbles are swapped or taken from the wrong addresses. If the pause logic or the output hold is broken, a byte is lost or changes under a stalled consumer. With a throttled consumer this appears within the first two bytes. A broken release of line 0 or a short chip-select gap is caught on the falling edge or on the deselect cycle where it happens.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_GAP
  } rd_state_e;

  localparam logic [7:0] RD_OPCODE  = 8'h6B;
  localparam int         OP_CLKS    = 8;
  localparam int         ADDR_BITS  = 24;
  localparam int         DUMMY_CLKS = 8;
  localparam int         HDR_BITS   = OP_CLKS + ADDR_BITS;
  localparam int         HDR_CLKS   = HDR_BITS + DUMMY_CLKS;
  localparam int         HCW        = $clog2(HDR_CLKS + 1);
  localparam int         NIB_W      = 4;

endpackage

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen #(
  parameter int CLK_DIV = 4,
  parameter int CPOL    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_c,
  output logic rise_tick,
  output logic end_tick,
  output logic at_start
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          idle_lvl;

  generate
    if (CPOL != 0) begin : g_idle_high
      assign idle_lvl = 1'b1;
    end else begin : g_idle_low
      assign idle_lvl = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == CW'(CLK_DIV - 1)) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end

  // low half first, then high half; idle level whenever paused
  assign sclk_c    = run ? (cnt >= CW'(HALF)) : idle_lvl;
  assign rise_tick = run && (cnt == CW'(HALF - 1));
  assign end_tick  = run && (cnt == CW'(CLK_DIV - 1));
  assign at_start  = (cnt == '0);

endmodule

// File: rtl/qspi_hdr_shift.sv
module qspi_hdr_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);

  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign bit_o = sh[W-1];

endmodule

// File: rtl/qspi_nib_asm.sv
module qspi_nib_asm #(
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic [NW-1:0]   nib,
  input  logic            rd_ready,
  output logic            hi_pending,
  output logic [2*NW-1:0] rd_data,
  output logic            rd_valid
);

  logic [NW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      hi_pending <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (cap) begin
        if (!hi_pending) begin
          hi_q       <= nib;
          hi_pending <= 1'b1;
        end else begin
          rd_data    <= {hi_q, nib};
          rd_valid   <= 1'b1;
          hi_pending <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
  import qspi_rd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CPOL    = 0,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             quad_en,
  output logic             sclk,
  output logic             cs_n,
  output logic             io0_o,
  output logic             io0_oe,
  input  logic [3:0]       io_i,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             err
);

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  rd_state_e        st;
  logic [HCW-1:0]   hdr_cnt;
  logic [LEN_W-1:0] bytes_left;
  logic [GW-1:0]    gap_cnt;
  logic             oe_r, cap_d;
  logic             run, stall, start;
  logic             sclk_c, rise_tick, end_tick, at_start;
  logic             hdr_bit, hi_pending;

  assign start = (st == ST_IDLE) && req_valid && quad_en && (req_len != '0);
  assign stall = (st == ST_DATA) && at_start && !hi_pending && rd_valid && !rd_ready;
  assign run   = ((st == ST_HDR) || (st == ST_DATA)) && !stall;
  assign req_ready = (st == ST_IDLE);

  qspi_sclk_gen #(.CLK_DIV(CLK_DIV), .CPOL(CPOL)) u_sclk (
    .clk(clk), .rst(rst), .run(run), .sclk_c(sclk_c),
    .rise_tick(rise_tick), .end_tick(end_tick), .at_start(at_start)
  );

  qspi_hdr_shift #(.W(HDR_BITS)) u_hdr (
    .clk(clk), .rst(rst), .load(start), .load_val({RD_OPCODE, req_addr}),
    .shift((st == ST_HDR) && end_tick), .bit_o(hdr_bit)
  );

  qspi_nib_asm #(.NW(NIB_W)) u_asm (
    .clk(clk), .rst(rst), .cap(cap_d), .nib(io_i), .rd_ready(rd_ready),
    .hi_pending(hi_pending), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // control state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      hdr_cnt    <= '0;
      bytes_left <= '0;
      gap_cnt    <= '0;
      oe_r       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (!quad_en)           err  <= 1'b1;
            else if (req_len == '0) done <= 1'b1;
            else begin
              st         <= ST_HDR;
              hdr_cnt    <= '0;
              bytes_left <= req_len;
              oe_r       <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (end_tick) begin
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_cnt == HCW'(HDR_BITS - 1)) oe_r <= 1'b0;
            if (hdr_cnt == HCW'(HDR_CLKS - 1)) st   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rise_tick && hi_pending) bytes_left <= bytes_left - 1'b1;
          if (end_tick && bytes_left == '0) begin
            st      <= ST_GAP;
            gap_cnt <= '0;
          end
        end
        ST_GAP: begin
          if (gap_cnt != GW'(GAP_CYC)) gap_cnt <= gap_cnt + 1'b1;
          else if (!rd_valid) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // aligned output stage; capture follows the registered rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk   <= (CPOL != 0);
      cs_n   <= 1'b1;
      io0_o  <= 1'b0;
      io0_oe <= 1'b0;
      cap_d  <= 1'b0;
    end else begin
      sclk   <= sclk_c;
      cs_n   <= (st == ST_IDLE) || (st == ST_GAP);
      io0_o  <= hdr_bit;
      io0_oe <= oe_r;
      cap_d  <= rise_tick && (st == ST_DATA);
    end
  end

endmodule

// File: rtl/qspi_quad_reader_chk.sv
module qspi_quad_reader_chk #(
  parameter int CLK_DIV = 4,
  parameter int CPOL    = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic       io0_oe,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       done,
  input logic       err
);

  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_MIN + 1);

  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          hi_cnt <= GW'(GAP_MIN);
    else if (!cs_n)                   hi_cnt <= '0;
    else if (hi_cnt != GW'(GAP_MIN))  hi_cnt <= hi_cnt + 1'b1;
  end

  p_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (sclk == (CPOL != 0)));

  p_hold_byte_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_refuse_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && !done));

  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= GW'(GAP_MIN)));

  p_done_drained_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_valid && cs_n));

  p_oe_selected_r5: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> !cs_n);

endmodule

bind qspi_quad_reader qspi_quad_reader_chk #(.CLK_DIV(CLK_DIV), .CPOL(CPOL)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io0_oe(io0_oe),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .done(done), .err(err)
);

// File: tb/qspi_quad_reader_tb.sv
`timescale 1ns/1ps
module qspi_quad_reader_tb_top;

  localparam int CLK_DIV = 4;
  localparam int CPOL    = 0;
  localparam int LEN_W   = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [23:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             quad_en = 1'b1;
  logic             sclk, cs_n, io0_o, io0_oe;
  logic [3:0]       io_i = '0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             rd_ready = 1'b1;
  logic             done, err;

  always #2.5 clk = ~clk;

  qspi_quad_reader #(.CLK_DIV(CLK_DIV), .CPOL(CPOL), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .quad_en(quad_en),
    .sclk(sclk), .cs_n(cs_n), .io0_o(io0_o), .io0_oe(io0_oe), .io_i(io_i),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int err_seen = 0;
  int cs_low_cycles = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [7:0]  exp_q[$];
  logic [23:0] cur_addr = '0;
  int          cur_len = 0;

  task automatic chk_eq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  // memory model and stream reference, evaluated away from the active edge
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          fl_bits = 0, gap_cycles = 1000;
  logic [31:0] fl_sh = '0;
  logic        pend_v = 1'b0;
  logic [7:0]  pend_d = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n) chk_eq("R8 sclk idle level", int'(sclk), CPOL);
      else cs_low_cycles++;
      if (prev_cs && !cs_n) begin
        chk_eq("R10 deselect gap ok", int'(gap_cycles >= 2*CLK_DIV), 1);
        fl_bits = 0;
      end
      if (cs_n) gap_cycles++; else gap_cycles = 0;
      if (!cs_n && !prev_sclk && sclk) begin
        if (fl_bits < 32) begin
          chk_eq("R5 line0 driven in header", int'(io0_oe), 1);
          fl_sh = {fl_sh[30:0], io0_o};
        end
        fl_bits++;
      end
      if (!cs_n && prev_sclk && !sclk && fl_bits >= 32)
        chk_eq("R5 line0 released", int'(io0_oe), 0);
      if (!cs_n && prev_sclk && !sclk && fl_bits >= 40) begin
        int n;
        logic [7:0] b;
        n = fl_bits - 40;
        b = fmem(fl_sh[23:0] + 24'(n / 2));
        io_i = (n % 2 == 0) ? b[7:4] : b[3:0];
      end
      if (!prev_cs && cs_n) begin
        chk_eq("R1 opcode", int'(fl_sh[31:24]), 8'h6B);
        chk_eq("R2 address", int'(fl_sh[23:0]), int'(cur_addr));
        chk_eq("R3 clock count", fl_bits, 40 + 2*cur_len);
      end
      if (pend_v) begin
        chk_eq("R9 valid held", int'(rd_valid), 1);
        chk_eq("R9 data stable", int'(rd_data), int'(pend_d));
      end
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) chk_eq("R4 unexpected byte", int'(rd_data), -1);
        else chk_eq("R4 byte value", int'(rd_data), int'(exp_q.pop_front()));
      end
      pend_v = rd_valid && !rd_ready;
      pend_d = rd_data;
      if (done) begin
        done_seen++;
        chk_eq("R11 done after last byte", exp_q.size(), 0);
        chk_eq("R11 done with cs high", int'(cs_n), 1);
      end
      if (err) err_seen++;
      prev_sclk = sclk;
      prev_cs = cs_n;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      rd_ready = (ready_mode != 0) ? (cyc % 5 == 0) : 1'b1;
    end
  end

  task automatic issue(input logic [23:0] a, input int len);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = LEN_W'(len);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, input int len);
    int d0;
    cur_addr = a;
    cur_len  = len;
    for (int i = 0; i < len; i++) exp_q.push_back(fmem(a + 24'(i)));
    d0 = done_seen;
    issue(a, len);
    @(negedge clk);
    chk_eq("R11 busy after accept", int'(req_ready), 0);
    while (done_seen == d0) @(negedge clk);
    chk_eq("R4 all bytes delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, d0, e0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk_eq("R12 cs_n after reset", int'(cs_n), 1);
    chk_eq("R12 sclk after reset", int'(sclk), CPOL);
    chk_eq("R12 oe after reset", int'(io0_oe), 0);
    chk_eq("R12 valid after reset", int'(rd_valid), 0);
    chk_eq("R12 ready after reset", int'(req_ready), 1);

    do_read(24'h123456, 5);
    do_read(24'hFFFFFE, 4);          // R4 address wrap
    ready_mode = 1;                  // R9 throttled consumer
    do_read(24'h00A0F0, 6);
    ready_mode = 0;

    // R6 refused request
    quad_en = 1'b0;
    c0 = cs_low_cycles; d0 = done_seen; e0 = err_seen;
    issue(24'h000400, 3);
    @(negedge clk);
    chk_eq("R6 err pulse", int'(err), 1);
    repeat (30) @(negedge clk);
    chk_eq("R6 single err", err_seen - e0, 1);
    chk_eq("R6 no cs activity", cs_low_cycles - c0, 0);
    chk_eq("R6 no done", done_seen - d0, 0);
    quad_en = 1'b1;

    // R7 zero length
    c0 = cs_low_cycles; d0 = done_seen;
    issue(24'h000800, 0);
    @(negedge clk);
    chk_eq("R7 done pulse", int'(done), 1);
    repeat (20) @(negedge clk);
    chk_eq("R7 single done", done_seen - d0, 1);
    chk_eq("R7 no cs activity", cs_low_cycles - c0, 0);

    // R10 back-to-back reads
    do_read(24'h000010, 2);
    do_read(24'h000100, 1);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule